// File: doc/BRIEF.md
# Event Buffer with Graded Throttle and Loss Accounting

This block is a byte-wide event store placed between a producer of zero-suppressed event fragments and a downstream link. The producer presents bytes with a start marker on the first byte and an end marker on the last byte of each event. The link drains bytes through a valid/ready port. An event becomes visible to the link only when its end byte has been stored. The link sees the bytes in write order, with the final byte of each event flagged.

If an event outgrows the free space, the block does not stall and does not pass on a truncated event. It removes the bytes of that event that were already stored and discards the rest. In their place it stores a two-byte placeholder: a loss marker followed by the event's number. The downstream event count therefore stays aligned. A sticky loss flag and a saturating lost-event counter record every such drop.

Two registered throttle outputs tell the producer how full the buffer is. Each has its own programmable byte level and a shared programmable hysteresis. Occupancy counts every stored byte, including the uncommitted bytes of the event being written.

Top module: `evt_loss_fifo`

## Requirements
- R1: The read port delivers committed bytes in write order. `rd_last` is 1 on the final byte of each event. While `rd_valid` is 1 and `rd_ready` is 0, `rd_valid` stays 1 and `rd_data`/`rd_last` stay unchanged.
- R2: No byte of an event is offered on the read port before the end byte of that event has been accepted.
- R3: A data byte is stored only if occupancy after storing it is at most DEPTH-2. Occupancy is bytes written (committed or not) minus bytes read. When a byte of an event fails this test, the event is dropped. Its bytes already stored are removed, and its remaining bytes are discarded up to and including its end byte.
- R4: A dropped event is replaced by exactly two bytes. The first is LOSS_MARK (default 8'hEE) with `rd_last`=0. The second is the event number modulo 256 with `rd_last`=1. Event numbers count start-marked accepted beats from reset, and the first event is number 0.
- R5: A drop sets `loss_flag`. The flag stays set until a one-cycle `clr_loss` pulse clears it on the next clock edge.
- R6: `lost_cnt` rises by one per dropped event and holds at 2^CNT_W-1 once it reaches that value. `clr_loss` does not change it.
- R7: `wr_ready` is 0 in the cycle after the end beat of a dropped event, when the second placeholder byte is written. It is also 0 whenever occupancy exceeds DEPTH-2. Otherwise it is 1.
- R8: `thr_warn` becomes 1 one cycle after occupancy reaches `warn_th`. It returns to 0 one cycle after occupancy + `hyst_len` falls below `warn_th`.
- R9: `thr_busy` follows the same rule as R8 with `busy_th`.
- R10: A beat without a start marker outside an event is ignored. It stores nothing and takes no event number.
- R11: After reset, `rd_valid`, `thr_warn`, `thr_busy`, `loss_flag` and `lost_cnt` are 0, and `wr_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Producer byte valid |
| wr_sof | input | 1 | Byte is first of an event |
| wr_eof | input | 1 | Byte is last of an event |
| wr_data | input | 8 | Producer byte |
| wr_ready | output | 1 | Block accepts a byte this cycle |
| rd_valid | output | 1 | Committed byte available |
| rd_ready | input | 1 | Link takes the byte |
| rd_data | output | 8 | Byte to the link |
| rd_last | output | 1 | Final byte of an event |
| warn_th | input | AW+1 | Warn occupancy level |
| busy_th | input | AW+1 | Busy occupancy level |
| hyst_len | input | AW+1 | Release hysteresis in bytes |
| thr_warn | output | 1 | Lower throttle level |
| thr_busy | output | 1 | Upper throttle level |
| clr_loss | input | 1 | Clears the loss flag |
| loss_flag | output | 1 | Sticky data-loss flag |
| lost_cnt | output | CNT_W | Saturating count of dropped events |

## Verification
The bench builds the block with DEPTH=16 and CNT_W=4, so only fourteen data bytes fit and the counter saturates at 15. With this size, every pairing of a leading event length (1 to 14) and a following event length (1 to 15) can be swept. The sweep covers exact fit, a drop at the first byte, a drop in mid-event, a single-byte drop and the full buffer after a placeholder. Event-number wrap and counter saturation also come up during the sweep. With thresholds of 6 and 12 and a hysteresis of 3, both throttle levels rise and fall inside one directed fill and drain.

// File: rtl/evtbuf_pkg.sv
package evtbuf_pkg;
   typedef enum logic [1:0] {
      WS_IDLE,
      WS_DATA,
      WS_DROP,
      WS_TAIL
   } wstate_t;

   typedef struct packed {
      logic       last;
      logic [7:0] data;
   } entry_t;

   localparam int NUM_W = 8;
endpackage

// File: rtl/evtbuf_store.sv
module evtbuf_store
   import evtbuf_pkg::*;
#(
   parameter int DEPTH = 2048,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  entry_t        wentry,
   input  logic [AW:0]   cm_ptr,
   input  logic          rd_ready,
   output logic          rd_valid,
   output logic [7:0]    rd_data,
   output logic          rd_last,
   output logic [AW:0]   rd_ptr
);
   entry_t mem [DEPTH];
   entry_t head;

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wentry;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                    rd_ptr <= '0;
      else if (rd_valid && rd_ready) rd_ptr <= rd_ptr + 1'b1;
   end

   assign head     = mem[rd_ptr[AW-1:0]];
   assign rd_valid = (rd_ptr != cm_ptr);
   assign rd_data  = head.data;
   assign rd_last  = head.last;

   // R1: an offered byte waits unchanged for the link
   assert_rd_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) && $stable(rd_last)));
endmodule

// File: rtl/evtbuf_level.sv
module evtbuf_level #(
   parameter int AW = 11
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [AW:0] occ,
   input  logic [AW:0] th,
   input  logic [AW:0] hyst,
   output logic        lvl
);
   logic [AW+1:0] rel_sum;
   logic          lvl_n;

   assign rel_sum = {1'b0, occ} + {1'b0, hyst};

   always_comb begin
      if (lvl) lvl_n = !(rel_sum < {1'b0, th});
      else     lvl_n = (occ >= th);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) lvl <= 1'b0;
      else        lvl <= lvl_n;
   end

   // R8/R9: rise only after reaching the level
   assert_lvl_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lvl) |-> ($past(occ) >= $past(th)));
   // R8/R9: release only below level minus hysteresis
   assert_lvl_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lvl) |-> (({1'b0, $past(occ)} + {1'b0, $past(hyst)}) < {1'b0, $past(th)}));
endmodule

// File: rtl/evtbuf_admit.sv
module evtbuf_admit
   import evtbuf_pkg::*;
#(
   parameter int          DEPTH     = 2048,
   parameter int          CNT_W     = 16,
   parameter logic [7:0]  LOSS_MARK = 8'hEE,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_valid,
   input  logic          wr_sof,
   input  logic          wr_eof,
   input  logic [7:0]    wr_data,
   output logic          wr_ready,
   input  logic [AW:0]   rd_ptr,
   input  logic          clr_loss,
   output logic          we,
   output logic [AW-1:0] waddr,
   output entry_t        wentry,
   output logic [AW:0]   wr_ptr,
   output logic [AW:0]   cm_ptr,
   output logic [AW:0]   occ,
   output logic          loss_flag,
   output logic [CNT_W-1:0] lost_cnt
);
   localparam logic [AW:0]      LIMIT   = (AW+1)'(DEPTH - 2);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   wstate_t          st, st_n;
   logic [AW:0]      wr_n, cm_n;
   logic [NUM_W-1:0] evt_num, evt_n, cur_num, num_n;
   logic             room, beat, drop;

   assign occ      = wr_ptr - rd_ptr;
   assign room     = (occ < LIMIT);
   assign wr_ready = (st != WS_TAIL) && (occ <= LIMIT);
   assign beat     = wr_valid && wr_ready;

   always_comb begin
      st_n   = st;
      wr_n   = wr_ptr;
      cm_n   = cm_ptr;
      num_n  = cur_num;
      evt_n  = evt_num;
      we     = 1'b0;
      waddr  = wr_ptr[AW-1:0];
      wentry = '{last: wr_eof, data: wr_data};
      drop   = 1'b0;
      case (st)
         WS_IDLE: begin
            if (beat && wr_sof) begin
               num_n = evt_num;
               evt_n = evt_num + 1'b1;
               if (room) begin
                  we   = 1'b1;
                  wr_n = wr_ptr + 1'b1;
                  if (wr_eof) cm_n = wr_ptr + 1'b1;
                  else        st_n = WS_DATA;
               end else begin
                  drop = 1'b1;
                  if (wr_eof) begin
                     we     = 1'b1;
                     wentry = '{last: 1'b0, data: LOSS_MARK};
                     wr_n   = wr_ptr + 1'b1;
                     st_n   = WS_TAIL;
                  end else begin
                     st_n = WS_DROP;
                  end
               end
            end
         end
         WS_DATA: begin
            if (beat) begin
               if (room) begin
                  we   = 1'b1;
                  wr_n = wr_ptr + 1'b1;
                  if (wr_eof) begin
                     cm_n = wr_ptr + 1'b1;
                     st_n = WS_IDLE;
                  end
               end else begin
                  drop  = 1'b1;
                  waddr = cm_ptr[AW-1:0];
                  if (wr_eof) begin
                     we     = 1'b1;
                     wentry = '{last: 1'b0, data: LOSS_MARK};
                     wr_n   = cm_ptr + 1'b1;
                     st_n   = WS_TAIL;
                  end else begin
                     wr_n = cm_ptr;
                     st_n = WS_DROP;
                  end
               end
            end
         end
         WS_DROP: begin
            if (beat && wr_eof) begin
               we     = 1'b1;
               wentry = '{last: 1'b0, data: LOSS_MARK};
               wr_n   = wr_ptr + 1'b1;
               st_n   = WS_TAIL;
            end
         end
         default: begin
            we     = 1'b1;
            wentry = '{last: 1'b1, data: 8'(cur_num)};
            wr_n   = wr_ptr + 1'b1;
            cm_n   = wr_ptr + 1'b1;
            st_n   = WS_IDLE;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= WS_IDLE;
         wr_ptr    <= '0;
         cm_ptr    <= '0;
         evt_num   <= '0;
         cur_num   <= '0;
         loss_flag <= 1'b0;
         lost_cnt  <= '0;
      end else begin
         st      <= st_n;
         wr_ptr  <= wr_n;
         cm_ptr  <= cm_n;
         evt_num <= evt_n;
         cur_num <= num_n;
         if (drop)          loss_flag <= 1'b1;
         else if (clr_loss) loss_flag <= 1'b0;
         if (drop && lost_cnt != CNT_MAX) lost_cnt <= lost_cnt + 1'b1;
      end
   end

   // R3: stored bytes never exceed capacity
   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((wr_ptr - rd_ptr) <= (AW+1)'(DEPTH)) && ((cm_ptr - rd_ptr) <= (AW+1)'(DEPTH)));
   // R2: commit point moves only with a stored final byte
   assert_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cm_ptr != $past(cm_ptr)) |-> $past(we && wentry.last));
   // R5: the flag rises only on a drop
   assert_flag_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(loss_flag) |-> $past(drop));
   // R6: the counter only steps up by one
   assert_cnt_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (lost_cnt != $past(lost_cnt)) |-> (lost_cnt == $past(lost_cnt) + 1'b1));
endmodule

// File: rtl/evt_loss_fifo.sv
module evt_loss_fifo
   import evtbuf_pkg::*;
#(
   parameter int         DEPTH     = 2048,
   parameter int         CNT_W     = 16,
   parameter logic [7:0] LOSS_MARK = 8'hEE,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_valid,
   input  logic             wr_sof,
   input  logic             wr_eof,
   input  logic [7:0]       wr_data,
   output logic             wr_ready,
   output logic             rd_valid,
   input  logic             rd_ready,
   output logic [7:0]       rd_data,
   output logic             rd_last,
   input  logic [AW:0]      warn_th,
   input  logic [AW:0]      busy_th,
   input  logic [AW:0]      hyst_len,
   output logic             thr_warn,
   output logic             thr_busy,
   input  logic             clr_loss,
   output logic             loss_flag,
   output logic [CNT_W-1:0] lost_cnt
);
   if (DEPTH < 8 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 8");
   end
   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
      $error("CNT_W must lie between 1 and 32");
   end

   logic          we;
   logic [AW-1:0] waddr;
   entry_t        wentry;
   logic [AW:0]   wr_ptr, cm_ptr, rd_ptr, occ;
   logic [AW:0]   lvl_th [2];
   logic [1:0]    lvl_q;

   evtbuf_admit #(.DEPTH(DEPTH), .CNT_W(CNT_W), .LOSS_MARK(LOSS_MARK)) u_admit (
      .clk, .rst_n, .wr_valid, .wr_sof, .wr_eof, .wr_data, .wr_ready,
      .rd_ptr, .clr_loss, .we, .waddr, .wentry, .wr_ptr, .cm_ptr, .occ,
      .loss_flag, .lost_cnt
   );

   evtbuf_store #(.DEPTH(DEPTH)) u_store (
      .clk, .rst_n, .we, .waddr, .wentry, .cm_ptr, .rd_ready,
      .rd_valid, .rd_data, .rd_last, .rd_ptr
   );

   assign lvl_th[0] = warn_th;
   assign lvl_th[1] = busy_th;

   for (genvar g = 0; g < 2; g++) begin : g_lvl
      evtbuf_level #(.AW(AW)) u_lvl (
         .clk, .rst_n, .occ, .th(lvl_th[g]), .hyst(hyst_len), .lvl(lvl_q[g])
      );
   end

   assign thr_warn = lvl_q[0];
   assign thr_busy = lvl_q[1];
endmodule

// File: tb/test_evt_loss_fifo.sv
module test_evt_loss_fifo;
   localparam int DEPTH = 16;
   localparam int CNT_W = 4;
   localparam int AW    = 4;
   localparam int CAP   = DEPTH - 2;
   localparam int MARK  = 8'hEE;

   logic clk = 1'b0, rst_n = 1'b0;
   logic wr_valid = 0, wr_sof = 0, wr_eof = 0, rd_ready = 0, clr_loss = 0;
   logic [7:0] wr_data = '0;
   logic wr_ready, rd_valid, rd_last, thr_warn, thr_busy, loss_flag;
   logic [7:0] rd_data;
   logic [AW:0] warn_th = 5'd6, busy_th = 5'd12, hyst_len = 5'd3;
   logic [CNT_W-1:0] lost_cnt;

   int checks = 0, fails = 0, evt = 0, drops = 0;
   bit done = 0;

   always #5 clk = ~clk;

   evt_loss_fifo #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_evt_loss_fifo (
      .clk, .rst_n, .wr_valid, .wr_sof, .wr_eof, .wr_data, .wr_ready,
      .rd_valid, .rd_ready, .rd_data, .rd_last, .warn_th, .busy_th, .hyst_len,
      .thr_warn, .thr_busy, .clr_loss, .loss_flag, .lost_cnt
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic beat(input logic s, input logic e, input logic [7:0] d);
      while (!wr_ready) begin @(posedge clk); #1; end
      wr_valid = 1; wr_sof = s; wr_eof = e; wr_data = d;
      @(posedge clk); #1;
      wr_valid = 0; wr_sof = 0; wr_eof = 0;
   endtask

   task automatic pop(input string req, input int d, input int l);
      chk(req, "rd_valid", rd_valid, 1);
      chk(req, "rd_data", rd_data, d);
      chk(req, "rd_last", rd_last, l);
      rd_ready = 1;
      @(posedge clk); #1;
      rd_ready = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      bit w, b;
      int occ;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R11 reset state
      chk("R11", "rd_valid", rd_valid, 0);
      chk("R11", "thr_warn", thr_warn, 0);
      chk("R11", "thr_busy", thr_busy, 0);
      chk("R11", "loss_flag", loss_flag, 0);
      chk("R11", "lost_cnt", lost_cnt, 0);
      chk("R11", "wr_ready", wr_ready, 1);

      // R10: stray beats outside an event
      beat(0, 0, 8'h55);
      beat(0, 1, 8'h56);
      @(posedge clk); #1;
      chk("R10", "rd_valid after stray beats", rd_valid, 0);

      // R2: no visibility before the end byte; R1 hold while stalled
      beat(1, 0, 8'hA1);
      beat(0, 0, 8'hA2);
      @(posedge clk); #1;
      chk("R2", "rd_valid mid event", rd_valid, 0);
      beat(0, 1, 8'hA3);
      evt++;
      repeat (3) @(posedge clk); #1;
      pop("R1", 8'hA1, 0);
      pop("R1", 8'hA2, 0);
      pop("R1", 8'hA3, 1);
      chk("R1", "rd_valid drained", rd_valid, 0);

      // Sweep of leading length P and following length L
      for (int p = 1; p <= CAP; p++) begin
         for (int l = 1; l <= 15; l++) begin
            bit ok;
            int bnum;
            ok = (p + l <= CAP);
            beat(1, (p == 1), 8'(p * 16));
            for (int i = 1; i < p; i++) beat(0, (i == p - 1), 8'(p * 16 + i));
            evt++;
            bnum = evt;
            beat(1, (l == 1), 8'(l * 9 + 128));
            for (int i = 1; i < l; i++) beat(0, (i == l - 1), 8'(l * 9 + 128 + i));
            evt++;
            if (!ok) begin
               drops++;
               chk("R7", "wr_ready in placeholder cycle", wr_ready, 0);
            end
            @(posedge clk); #1;
            chk("R7", "wr_ready after pair", wr_ready, ((p + (ok ? l : 2)) <= CAP) ? 1 : 0);
            chk("R5", "loss_flag", loss_flag, ok ? 0 : 1);
            chk("R6", "lost_cnt", lost_cnt, (drops > 15) ? 15 : drops);
            for (int i = 0; i < p; i++) pop("R1", (p * 16 + i) & 255, (i == p - 1));
            if (ok) begin
               for (int i = 0; i < l; i++) pop("R3", (l * 9 + 128 + i) & 255, (i == l - 1));
            end else begin
               pop("R4", MARK, 0);
               pop("R4", bnum & 255, 1);
            end
            chk("R3", "rd_valid drained", rd_valid, 0);
            clr_loss = 1;
            @(posedge clk); #1;
            clr_loss = 0;
            chk("R5", "loss_flag cleared", loss_flag, 0);
            chk("R6", "lost_cnt kept by clear", lost_cnt, (drops > 15) ? 15 : drops);
         end
      end

      // R8/R9 throttle fill and drain against an arithmetic model
      repeat (2) @(posedge clk); #1;
      w = 0; b = 0; occ = 0;
      chk("R8", "warn idle", thr_warn, 0);
      for (int i = 0; i < CAP; i++) begin
         beat((i == 0), (i == CAP - 1), 8'(i));
         occ++;
         @(posedge clk); #1;
         w = w ? !(occ + 3 < 6) : (occ >= 6);
         b = b ? !(occ + 3 < 12) : (occ >= 12);
         chk("R8", "thr_warn on fill", thr_warn, w);
         chk("R9", "thr_busy on fill", thr_busy, b);
      end
      evt++;
      for (int i = 0; i < CAP; i++) begin
         pop("R1", i, (i == CAP - 1));
         occ--;
         @(posedge clk); #1;
         w = w ? !(occ + 3 < 6) : (occ >= 6);
         b = b ? !(occ + 3 < 12) : (occ >= 12);
         chk("R8", "thr_warn on drain", thr_warn, w);
         chk("R9", "thr_busy on drain", thr_busy, b);
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule